// File: doc/BRIEF.md
# Fixed-Map Address Remapper

This block turns a 32-bit logical address into a physical address using a small set of hard-wired region rules, not page tables. A two-bit mode register picks the behaviour. In the disabled setting, addresses are not changed. In the pass-through setting, program addresses are also not changed. In the compact setting, the address is first cut to its low 24 bits. Then one of three upper regions of that 24-bit space is moved into a high physical window.

Each request has an address and a flag that marks it as a program-space access. The translated address and a valid strobe come out of a register one clock later. Only program-space requests are ever rewritten. All other requests keep their full 32-bit address.

Top module: `fixed_map_remap`

## Requirements
- R1: After reset, the mode is disabled (code 0), `out_valid` is 0 and `out_addr` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 in every other cycle.
- R3: While the mode is 0, or for any request with `req_prog` low, `out_addr` equals the full 32-bit request address.
- R4: In pass-through mode (code 1), program requests come out with the full 32-bit address unchanged.
- R5: In compact mode (code 2), a program address whose low 24 bits are below 0xA00000 comes out as those 24 bits, with bits 31..24 cleared.
- R6: In compact mode, low 24 bits from 0xA00000 up to 0xDFFFFF come out as those 24 bits OR 0x40000000.
- R7: In compact mode, low 24 bits from 0xE00000 up to 0xEFFFFF come out as the low 20 bits OR 0xFE000000.
- R8: In compact mode, low 24 bits of 0xF00000 or more come out as those 24 bits OR 0x50000000.
- R9: A mode write with code 3 is ignored, and the previous mode stays in force.
- R10: A request made in the same cycle as a mode write is translated with the mode held before that write.
- R11: In a cycle with no request, `out_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Mode write enable |
| cfg_mode | input | 2 | Mode code to write: 0 disabled, 1 pass-through, 2 compact |
| req_valid | input | 1 | Request strobe |
| req_prog | input | 1 | 1 for a program-space request |
| req_addr | input | 32 | Logical request address |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 32 | Translated physical address |

## Verification
A mode register that holds the wrong code, or that takes the reserved code, shows up on the first program request after it. That request gets the wrong upper byte, or keeps upper bits that should have been stripped. The error is seen one cycle after the request. A fault in the region decoder shows up only for addresses near a window edge, so the bench drives each boundary value (just below 0xA00000, 0xDFFFFF, 0xE00000, 0xEFFFFF, 0xF00000) directly. It then adds random addresses across all modes and both space settings, and compares them against a behavioural model on every clock.

// File: rtl/remap_pkg.sv
`timescale 1ns/1ps
package remap_pkg;

   typedef enum logic [1:0] {
      RM_OFF     = 2'd0,
      RM_PASS    = 2'd1,
      RM_COMPACT = 2'd2,
      RM_RSVD    = 2'd3
   } remap_mode_e;

   localparam int RM_RULES = 3;

   function automatic logic rm_code_ok(input logic [1:0] code);
      return code != RM_RSVD;
   endfunction

endpackage

// File: rtl/remap_mode_reg.sv
`timescale 1ns/1ps
module remap_mode_reg
   import remap_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_code,
   output remap_mode_e mode_q
);

   logic take;
   assign take = wr_en && rm_code_ok(wr_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= RM_OFF;
      else if (take)
         mode_q <= remap_mode_e'(wr_code);
   end

   // R9
   rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_code == 2'd3) |=> $stable(mode_q));

   // R9
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != RM_RSVD);

endmodule

// File: rtl/remap_fixed_map.sv
`timescale 1ns/1ps
module remap_fixed_map
   import remap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LOW_W  = 24,
   parameter int RULES  = RM_RULES,
   parameter logic [ADDR_W-1:0] RULE_LO   [RULES] = '{32'h00A0_0000, 32'h00E0_0000, 32'h00F0_0000},
   parameter logic [ADDR_W-1:0] RULE_HI   [RULES] = '{32'h00DF_FFFF, 32'h00EF_FFFF, 32'h00FF_FFFF},
   parameter logic [ADDR_W-1:0] RULE_KEEP [RULES] = '{32'h00FF_FFFF, 32'h000F_FFFF, 32'h00FF_FFFF},
   parameter logic [ADDR_W-1:0] RULE_OR   [RULES] = '{32'h4000_0000, 32'hFE00_0000, 32'h5000_0000}
)(
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int PAD_W = ADDR_W - LOW_W;

   generate
      if (LOW_W >= ADDR_W || LOW_W < 1) begin : g_bad_width
         $error("remap_fixed_map: LOW_W must lie in 1..ADDR_W-1");
      end
      if (RULES < 1) begin : g_bad_rules
         $error("remap_fixed_map: RULES must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] low_addr;
   assign low_addr = {{PAD_W{1'b0}}, addr_in[LOW_W-1:0]};

   logic [RULES-1:0]  hit;
   logic [ADDR_W-1:0] cand [RULES];

   generate
      for (genvar g = 0; g < RULES; g++) begin : g_rule
         assign hit[g]  = (low_addr >= RULE_LO[g]) && (low_addr <= RULE_HI[g]);
         assign cand[g] = (low_addr & RULE_KEEP[g]) | RULE_OR[g];
      end
   endgenerate

   always_comb begin
      addr_out = low_addr;
      for (int k = RULES - 1; k >= 0; k--) begin
         if (hit[k])
            addr_out = cand[k];
      end
   end

   // R6 R7 R8: windows must never overlap
   always_comb begin
      hits_disjoint_chk: assert ($onehot0(hit));
   end

endmodule

// File: rtl/remap_out_stage.sv
`timescale 1ns/1ps
module remap_out_stage #(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d_addr,
   output logic              q_valid,
   output logic [ADDR_W-1:0] q_addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_addr  <= '0;
      end else begin
         q_valid <= load;
         if (load)
            q_addr <= d_addr;
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q_valid);

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> !q_valid);

endmodule

// File: rtl/fixed_map_remap.sv
`timescale 1ns/1ps
module fixed_map_remap
   import remap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LOW_W  = 24
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_mode,
   input  logic              req_valid,
   input  logic              req_prog,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr
);

   remap_mode_e       mode_q;
   logic [ADDR_W-1:0] mapped;
   logic [ADDR_W-1:0] chosen;
   logic              use_map;

   remap_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_code (cfg_mode),
      .mode_q  (mode_q)
   );

   remap_fixed_map #(
      .ADDR_W (ADDR_W),
      .LOW_W  (LOW_W)
   ) u_map (
      .addr_in  (req_addr),
      .addr_out (mapped)
   );

   assign use_map = req_prog && (mode_q == RM_COMPACT);
   assign chosen  = use_map ? mapped : req_addr;

   remap_out_stage #(
      .ADDR_W (ADDR_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (req_valid),
      .d_addr  (chosen),
      .q_valid (out_valid),
      .q_addr  (out_addr)
   );

   // R3
   off_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (mode_q == RM_OFF || !req_prog)) |=> out_addr == $past(req_addr));

   // R4
   pass_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_prog && mode_q == RM_PASS) |=> out_addr == $past(req_addr));

   // R6
   window_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && use_map && req_addr[23:20] >= 4'hA && req_addr[23:20] <= 4'hD)
      |=> out_addr[31:24] == 8'h40);

   // R11
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(out_addr));

endmodule

// File: tb/fixed_map_remap_tb_top.sv
`timescale 1ns/1ps
module fixed_map_remap_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        req_valid = 1'b0;
   logic        req_prog = 1'b0;
   logic [31:0] req_addr = 32'd0;
   logic        out_valid;
   logic [31:0] out_addr;

   always #5 clk = ~clk;

   fixed_map_remap dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_mode  (cfg_mode),
      .req_valid (req_valid),
      .req_prog  (req_prog),
      .req_addr  (req_addr),
      .out_valid (out_valid),
      .out_addr  (out_addr)
   );

   int    n_run = 0;
   int    n_fail = 0;
   int    m_mode = 0;
   bit    e_valid = 1'b0;
   logic [31:0] e_addr = 32'd0;
   string e_tag = "R1";
   bit    done = 1'b0;

   function automatic longint unsigned model(int md, bit prog, longint unsigned a);
      longint unsigned l;
      if (!prog || md != 2) return a;
      l = a % 64'h100_0000;
      if (l < 64'hA0_0000) return l;
      if (l < 64'hE0_0000) return l + 64'h4000_0000;
      if (l < 64'hF0_0000) return (l % 64'h10_0000) + 64'hFE00_0000;
      return l + 64'h5000_0000;
   endfunction

   function automatic string tag_of(int md, bit prog, longint unsigned a);
      longint unsigned l;
      if (!prog || md == 0) return "R3";
      if (md == 1) return "R4";
      l = a % 64'h100_0000;
      if (l < 64'hA0_0000) return "R5";
      if (l < 64'hE0_0000) return "R6";
      if (l < 64'hF0_0000) return "R7";
      return "R8";
   endfunction

   task automatic check_now();
      n_run++;
      if (out_valid !== e_valid) begin
         n_fail++;
         $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, e_valid);
      end
      n_run++;
      if (out_addr !== e_addr) begin
         n_fail++;
         $display("FAIL %s out_addr actual=%h expected=%h", e_valid ? e_tag : "R11", out_addr, e_addr);
      end
   endtask

   task automatic step(bit we, int code, bit v, bit prog, logic [31:0] a, string force_tag);
      @(negedge clk);
      check_now();
      cfg_we = we; cfg_mode = code[1:0];
      req_valid = v; req_prog = prog; req_addr = a;
      e_valid = v;
      if (v) begin
         e_addr = model(m_mode, prog, {32'd0, a})[31:0];
         e_tag  = (force_tag != "") ? force_tag : tag_of(m_mode, prog, {32'd0, a});
      end
      if (we && code != 3) m_mode = code;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      n_run++;
      if (out_valid !== 1'b0 || out_addr !== 32'd0) begin
         n_fail++;
         $display("FAIL R1 reset actual=%0b/%h expected=0/00000000", out_valid, out_addr);
      end
      rst_n = 1'b1;
      // R1: mode disabled after reset, so a program address is untouched
      step(0, 0, 1, 1, 32'hFFF0_1234, "R1");
      step(0, 0, 1, 0, 32'h12F0_0000, "");
      step(0, 0, 0, 0, 32'h0, "");
      // R4 pass-through
      step(1, 1, 0, 0, 32'h0, "");
      step(0, 0, 1, 1, 32'hABE1_2345, "");
      step(0, 0, 1, 1, 32'h0000_0010, "");
      // compact mode, boundaries R5..R8
      step(1, 2, 0, 0, 32'h0, "");
      step(0, 0, 1, 1, 32'h779F_FFFF, "");
      step(0, 0, 1, 1, 32'h00A0_0000, "");
      step(0, 0, 1, 1, 32'hFFDF_FFFF, "");
      step(0, 0, 1, 1, 32'h00E0_0000, "");
      step(0, 0, 1, 1, 32'h31EF_FFFF, "");
      step(0, 0, 1, 1, 32'h00F0_0000, "");
      step(0, 0, 1, 1, 32'h88FF_FFFF, "");
      step(0, 0, 1, 0, 32'h88E1_2345, "");
      // R11 idle holds
      step(0, 0, 0, 1, 32'h0012_3456, "");
      step(0, 0, 0, 0, 32'hDEAD_BEEF, "");
      // R9 reserved code ignored: stays compact
      step(1, 3, 0, 0, 32'h0, "");
      step(0, 0, 1, 1, 32'hFFE5_4321, "R9");
      // R10 write and request together: old mode (compact) applies
      step(1, 0, 1, 1, 32'h12C0_0001, "R10");
      step(0, 0, 1, 1, 32'h12C0_0001, "R10");
      // random mix
      for (int i = 0; i < 400; i++) begin
         int rc;
         rc = $urandom_range(0, 9);
         step(rc == 0, $urandom_range(0, 3), $urandom_range(0, 3) != 0,
              $urandom_range(0, 3) != 0, $urandom(), "");
      end
      step(0, 0, 0, 0, 32'h0, "");
      @(negedge clk);
      check_now();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule